// File: doc/BRIEF.md
# Condition Code Flag Register

This block holds the eight condition bits of a small 8-bit processor core: five status flags that describe the last arithmetic result and three bits that control interrupt acceptance. Each ALU operation presents its operands, its carry-in, its result, the bit that a shift pushed out and a 3-bit class code. On the next clock edge the flags that belong to that class are updated. The half-carry and carry are derived from the operands inside the block, while negative and zero come from the presented result. Classes that have no meaning for a flag leave that flag alone.

Software can overwrite all eight bits at once. That write beats a flag update arriving in the same cycle. The byte is also presented as the low half of a 16-bit status word whose top five bits carry an externally held register-bank pointer.

A combinational qualifier tells the interrupt logic whether a pending request of a given 2-bit level may be taken. It is true only when interrupts are globally enabled and the request level is numerically below the stored level, because a lower number means more urgent.

Top module: `ccFlagUnit`

## Requirements
- R1: While reset is low, and after it is released until the first write, the interrupt enable bit reads 0 and the 2-bit level field reads 11. The other five flags carry no guaranteed reset value.
- R2: The byte `ccr` is laid out, from bit 7 down to bit 0, as half carry, interrupt enable, level high, level low, negative, zero, overflow, carry. `statusWord` equals {bankPtr, 3'b000, ccr}.
- R3: For class 0 (add), carry becomes the carry out of bit 7 of opA+opB+carryIn, and half carry becomes the carry out of bit 3 of that sum.
- R4: For class 1 (subtract), carry becomes 1 when opA < opB+carryIn (borrow into bit 7). Half carry becomes 1 when opA[3:0] < opB[3:0]+carryIn (borrow from bit 4 into bit 3).
- R5: For classes 0 to 4, negative takes bit 7 of aluResult, and zero is 1 exactly when aluResult is 0.
- R6: For add, overflow is (a7==b7)&&(r7!=a7). For subtract, overflow is (a7!=b7)&&(r7!=a7). Here a7, b7 and r7 are bit 7 of opA, opB and aluResult.
- R7: For class 2 (shift), carry takes shiftOut, overflow is cleared and half carry is unchanged.
- R8: For class 3 (logic), overflow is cleared, while carry and half carry are unchanged.
- R9: For class 4 (move), only negative and zero change; half carry, overflow and carry keep their values.
- R10: With opValid low, or with class 5, 6 or 7, the byte is unchanged. No operation class ever alters the enable or level bits.
- R11: When swWrite is high, ccr equals swData after the next edge, even if opValid is high in the same cycle.
- R12: irqAccept is 1 exactly when irqReq is 1, the enable bit is 1, and irqLevel is numerically lower than the level field. It follows its inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An ALU operation completes this cycle |
| opClass | input | 3 | Operation class code (0 add, 1 sub, 2 shift, 3 logic, 4 move) |
| opA | input | 8 | First ALU operand |
| opB | input | 8 | Second ALU operand |
| carryIn | input | 1 | Carry or borrow into the ALU operation |
| aluResult | input | 8 | ALU result |
| shiftOut | input | 1 | Bit shifted out by a shift operation |
| swWrite | input | 1 | Whole-byte software write strobe |
| swData | input | 8 | Byte to write |
| bankPtr | input | 5 | Register-bank pointer for the status word |
| irqReq | input | 1 | Interrupt request pending |
| irqLevel | input | 2 | Level of the pending request |
| ccr | output | 8 | Condition code byte |
| statusWord | output | 16 | Bank pointer, padding and condition byte |
| irqAccept | output | 1 | Request may be accepted |

## Verification
A wrong internal flag shows at `ccr` one edge after the operation that produced it, and it shows in `irqAccept` in the same cycle for the enable and level bits. A flag that silently drifts is visible only through a later operation of a class that should leave it alone. For that reason, each vector first presets the byte through the software write and then applies one operation. Any error in the decode of which class updates which flag then appears as a single-bit mismatch on the very next sample.

// File: rtl/ccFlagPkg.sv
package ccFlagPkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_SHIFT = 3'd2,
    OP_LOGIC = 3'd3,
    OP_MOVE  = 3'd4
  } opClassE;

  // bit positions inside the condition byte
  localparam int POS_C   = 0;
  localparam int POS_V   = 1;
  localparam int POS_Z   = 2;
  localparam int POS_N   = 3;
  localparam int POS_IL0 = 4;
  localparam int POS_IL1 = 5;
  localparam int POS_I   = 6;
  localparam int POS_H   = 7;
  localparam int CCR_W   = 8;
  localparam int LVL_W   = 2;

  // strobes from the decoder to the flag datapath
  typedef struct packed {
    logic loadAll;
    logic updH;
    logic updNZ;
    logic updV;
    logic clrV;
    logic updC;
    logic cFromShift;
    logic subMode;
  } flagStrobeT;

endpackage

// File: rtl/ccFlagCtrl.sv
module ccFlagCtrl
  import ccFlagPkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opClass,
  input  logic       swWrite,
  output flagStrobeT strb
);

  always_comb begin
    strb = '0;
    if (swWrite) begin
      strb.loadAll = 1'b1;
    end else if (opValid) begin
      unique case (opClass)
        OP_ADD: begin
          strb.updH  = 1'b1;
          strb.updNZ = 1'b1;
          strb.updV  = 1'b1;
          strb.updC  = 1'b1;
        end
        OP_SUB: begin
          strb.updH    = 1'b1;
          strb.updNZ   = 1'b1;
          strb.updV    = 1'b1;
          strb.updC    = 1'b1;
          strb.subMode = 1'b1;
        end
        OP_SHIFT: begin
          strb.updNZ      = 1'b1;
          strb.clrV       = 1'b1;
          strb.updC       = 1'b1;
          strb.cFromShift = 1'b1;
        end
        OP_LOGIC: begin
          strb.updNZ = 1'b1;
          strb.clrV  = 1'b1;
        end
        OP_MOVE: begin
          strb.updNZ = 1'b1;
        end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/ccFlagPath.sv
module ccFlagPath
  import ccFlagPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobeT        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              shiftOut,
  input  logic [CCR_W-1:0]  swData,
  output logic [CCR_W-1:0]  ccr
);

  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  logic [DATA_W:0] addFull, subFull;
  logic [HALF:0]   addHalf, subHalf;
  logic            carryNext, halfNext, ovfNext;
  logic            hFlag, iEn, nFlag, zFlag, vFlag, cFlag;
  logic [LVL_W-1:0] ilLvl;

  // carries are rebuilt from the operands; the top bit of each
  // widened sum or difference is the carry or the borrow
  always_comb begin
    addFull = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
    subFull = {1'b0, opA} - {1'b0, opB} - {{DATA_W{1'b0}}, carryIn};
    addHalf = {1'b0, opA[HALF-1:0]} + {1'b0, opB[HALF-1:0]} + {{HALF{1'b0}}, carryIn};
    subHalf = {1'b0, opA[HALF-1:0]} - {1'b0, opB[HALF-1:0]} - {{HALF{1'b0}}, carryIn};
    if (strb.subMode) begin
      carryNext = subFull[DATA_W];
      halfNext  = subHalf[HALF];
      ovfNext   = (opA[MSB] != opB[MSB]) && (aluResult[MSB] != opA[MSB]);
    end else begin
      carryNext = addFull[DATA_W];
      halfNext  = addHalf[HALF];
      ovfNext   = (opA[MSB] == opB[MSB]) && (aluResult[MSB] != opA[MSB]);
    end
  end

  // interrupt control bits: defined reset, touched only by software
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iEn   <= 1'b0;
      ilLvl <= '1;
    end else if (strb.loadAll) begin
      iEn   <= swData[POS_I];
      ilLvl <= swData[POS_IL1:POS_IL0];
    end
  end

  // arithmetic flags: cleared on reset though no value is promised
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hFlag <= 1'b0;
      nFlag <= 1'b0;
      zFlag <= 1'b0;
      vFlag <= 1'b0;
      cFlag <= 1'b0;
    end else if (strb.loadAll) begin
      hFlag <= swData[POS_H];
      nFlag <= swData[POS_N];
      zFlag <= swData[POS_Z];
      vFlag <= swData[POS_V];
      cFlag <= swData[POS_C];
    end else begin
      if (strb.updH) hFlag <= halfNext;
      if (strb.updNZ) begin
        nFlag <= aluResult[MSB];
        zFlag <= (aluResult == '0);
      end
      if (strb.updV)      vFlag <= ovfNext;
      else if (strb.clrV) vFlag <= 1'b0;
      if (strb.updC) cFlag <= strb.cFromShift ? shiftOut : carryNext;
    end
  end

  always_comb begin
    ccr                   = '0;
    ccr[POS_H]            = hFlag;
    ccr[POS_I]            = iEn;
    ccr[POS_IL1:POS_IL0]  = ilLvl;
    ccr[POS_N]            = nFlag;
    ccr[POS_Z]            = zFlag;
    ccr[POS_V]            = vFlag;
    ccr[POS_C]            = cFlag;
  end

endmodule

// File: rtl/ccIrqGate.sv
module ccIrqGate
  import ccFlagPkg::*;
(
  input  logic [CCR_W-1:0] ccr,
  input  logic             irqReq,
  input  logic [LVL_W-1:0] irqLevel,
  output logic             irqAccept
);

  logic [LVL_W-1:0] heldLvl;

  always_comb begin
    heldLvl   = ccr[POS_IL1:POS_IL0];
    irqAccept = irqReq && ccr[POS_I] && (irqLevel < heldLvl);
  end

endmodule

// File: rtl/ccFlagUnit.sv
module ccFlagUnit
  import ccFlagPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 5,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opClass,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              shiftOut,
  input  logic              swWrite,
  input  logic [7:0]        swData,
  input  logic [BANK_W-1:0] bankPtr,
  input  logic              irqReq,
  input  logic [1:0]        irqLevel,
  output logic [7:0]        ccr,
  output logic [STAT_W-1:0] statusWord,
  output logic              irqAccept
);

  localparam int PAD_W = STAT_W - BANK_W - CCR_W;

  flagStrobeT strb;

  ccFlagCtrl ctrl_i (
    .opValid (opValid),
    .opClass (opClass),
    .swWrite (swWrite),
    .strb    (strb)
  );

  ccFlagPath #(.DATA_W(DATA_W)) path_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .aluResult (aluResult),
    .shiftOut  (shiftOut),
    .swData    (swData),
    .ccr       (ccr)
  );

  ccIrqGate gate_i (
    .ccr       (ccr),
    .irqReq    (irqReq),
    .irqLevel  (irqLevel),
    .irqAccept (irqAccept)
  );

  assign statusWord = {bankPtr, {PAD_W{1'b0}}, ccr};

endmodule

// File: rtl/ccFlagChecker.sv
module ccFlagChecker (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [2:0] opClass,
  input logic [7:0] opA,
  input logic [7:0] opB,
  input logic       carryIn,
  input logic [7:0] aluResult,
  input logic       shiftOut,
  input logic       swWrite,
  input logic [7:0] swData,
  input logic       irqReq,
  input logic [1:0] irqLevel,
  input logic [7:0] ccr,
  input logic       irqAccept
);

  logic [8:0] sumWide, diffWide;
  logic       opAdd, opSub, opShift, opNz, opIdle;

  always_comb begin
    sumWide  = {1'b0, opA} + {1'b0, opB} + {8'b0, carryIn};
    diffWide = {1'b0, opA} - {1'b0, opB} - {8'b0, carryIn};
    opAdd    = !swWrite && opValid && (opClass == 3'd0);
    opSub    = !swWrite && opValid && (opClass == 3'd1);
    opShift  = !swWrite && opValid && (opClass == 3'd2);
    opNz     = !swWrite && opValid && (opClass <= 3'd4);
    opIdle   = !swWrite && (!opValid || (opClass > 3'd4));
  end

  assert_reset_ctrl_R1: assert property (@(posedge clk)
    !rstN |=> (ccr[6:4] == 3'b011));

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    opAdd |=> (ccr[0] == $past(sumWide[8])));

  assert_sub_borrow_R4: assert property (@(posedge clk) disable iff (!rstN)
    opSub |=> (ccr[0] == $past(diffWide[8])));

  assert_nz_track_R5: assert property (@(posedge clk) disable iff (!rstN)
    opNz |=> ((ccr[3] == $past(aluResult[7])) && (ccr[2] == ($past(aluResult) == 8'h00))));

  assert_shift_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    opShift |=> ((ccr[0] == $past(shiftOut)) && !ccr[1] && (ccr[7] == $past(ccr[7]))));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    opIdle |=> $stable(ccr));

  assert_ctrl_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    !swWrite |=> $stable(ccr[6:4]));

  assert_sw_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    swWrite |=> (ccr == $past(swData)));

  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqAccept |-> (irqReq && ccr[6] && (irqLevel < ccr[5:4])));

endmodule

bind ccFlagUnit ccFlagChecker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opClass   (opClass),
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .aluResult (aluResult),
  .shiftOut  (shiftOut),
  .swWrite   (swWrite),
  .swData    (swData),
  .irqReq    (irqReq),
  .irqLevel  (irqLevel),
  .ccr       (ccr),
  .irqAccept (irqAccept)
);

// File: tb/ccFlagUnit_tb_top.sv
`timescale 1ns/1ps
module ccFlagUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opClass = 3'd0;
  logic [7:0]  opA = 8'h00, opB = 8'h00, aluResult = 8'h00, swData = 8'h00;
  logic        carryIn = 1'b0, shiftOut = 1'b0, swWrite = 1'b0;
  logic [4:0]  bankPtr = 5'h15;
  logic        irqReq = 1'b0;
  logic [1:0]  irqLevel = 2'd0;
  logic [7:0]  ccr;
  logic [15:0] statusWord;
  logic        irqAccept;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccFlagUnit dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .opA(opA), .opB(opB), .carryIn(carryIn), .aluResult(aluResult),
    .shiftOut(shiftOut), .swWrite(swWrite), .swData(swData),
    .bankPtr(bankPtr), .irqReq(irqReq), .irqLevel(irqLevel),
    .ccr(ccr), .statusWord(statusWord), .irqAccept(irqAccept)
  );

  typedef struct packed {
    logic [7:0] pre;
    logic [2:0] cls;
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic [7:0] res;
    logic       sh;
    logic [7:0] expCcr;
  } vecT;

  localparam int NVEC = 14;
  localparam vecT VECS [NVEC] = '{
    '{8'h30, 3'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 1'b0, 8'hB0},
    '{8'h30, 3'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 8'hBA},
    '{8'h30, 3'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b0, 8'hB5},
    '{8'hBF, 3'd0, 8'h12, 8'h34, 1'b1, 8'h47, 1'b0, 8'h30},
    '{8'h30, 3'd1, 8'h10, 8'h01, 1'b0, 8'h0F, 1'b0, 8'hB0},
    '{8'h30, 3'd1, 8'h80, 8'h01, 1'b0, 8'h7F, 1'b0, 8'hB2},
    '{8'h30, 3'd1, 8'h05, 8'h05, 1'b1, 8'hFF, 1'b0, 8'hB9},
    '{8'hB1, 3'd1, 8'h40, 8'h40, 1'b0, 8'h00, 1'b0, 8'h34},
    '{8'hB2, 3'd2, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'hB5},
    '{8'h31, 3'd2, 8'hFF, 8'hFF, 1'b1, 8'h81, 1'b0, 8'h38},
    '{8'hB3, 3'd3, 8'h0F, 8'hF0, 1'b0, 8'h00, 1'b1, 8'hB5},
    '{8'h73, 3'd4, 8'h00, 8'h00, 1'b1, 8'h80, 1'b0, 8'h7B},
    '{8'h5A, 3'd5, 8'hFF, 8'h01, 1'b1, 8'h00, 1'b1, 8'h5A},
    '{8'h50, 3'd0, 8'h01, 8'h01, 1'b0, 8'h02, 1'b0, 8'h50}
  };

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic presetCcr(input logic [7:0] val);
    @(negedge clk);
    opValid = 1'b0;
    swWrite = 1'b1;
    swData  = val;
    @(negedge clk);
    swWrite = 1'b0;
  endtask

  function automatic string tagFor(input logic [2:0] c);
    case (c)
      3'd0:    return "R3 R6";
      3'd1:    return "R4 R6";
      3'd2:    return "R7";
      3'd3:    return "R8";
      3'd4:    return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check(ccr[6:4] == 3'b011, "R1 in reset", {8'h0, ccr}, 16'h0030);
    rstN = 1'b1;
    @(negedge clk);
    check(ccr[6:4] == 3'b011, "R1 after release", {8'h0, ccr}, 16'h0030);
    check(statusWord == {bankPtr, 3'b000, ccr}, "R2 status word", statusWord, {bankPtr, 3'b000, ccr});

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      presetCcr(VECS[i].pre);
      opValid   = 1'b1;
      opClass   = VECS[i].cls;
      opA       = VECS[i].a;
      opB       = VECS[i].b;
      carryIn   = VECS[i].cin;
      aluResult = VECS[i].res;
      shiftOut  = VECS[i].sh;
      @(negedge clk);
      opValid = 1'b0;
      check(ccr == VECS[i].expCcr, tagFor(VECS[i].cls), {8'h0, ccr}, {8'h0, VECS[i].expCcr});
      if (VECS[i].cls <= 3'd4)
        check(ccr[3:2] == VECS[i].expCcr[3:2], "R5 negative/zero", {14'h0, ccr[3:2]}, {14'h0, VECS[i].expCcr[3:2]});
    end

    // layout of the status word with a different bank pointer
    bankPtr = 5'h0A;
    presetCcr(8'hC6);
    check(statusWord == 16'h50C6, "R2 layout", statusWord, 16'h50C6);

    // opValid low: nothing changes
    presetCcr(8'h9C);
    @(negedge clk);
    opValid = 1'b0; opClass = 3'd0; opA = 8'hFF; opB = 8'hFF; aluResult = 8'h00;
    @(negedge clk);
    check(ccr == 8'h9C, "R10 idle hold", {8'h0, ccr}, 16'h009C);

    // software write collides with an add
    @(negedge clk);
    swWrite = 1'b1; swData = 8'h4C;
    opValid = 1'b1; opClass = 3'd0; opA = 8'hFF; opB = 8'h01; carryIn = 1'b0; aluResult = 8'h00;
    @(negedge clk);
    swWrite = 1'b0; opValid = 1'b0;
    check(ccr == 8'h4C, "R11 write wins", {8'h0, ccr}, 16'h004C);

    // interrupt qualifier
    presetCcr(8'h60);
    irqReq = 1'b1; irqLevel = 2'd1; #1;
    check(irqAccept == 1'b1, "R12 lower level taken", {15'h0, irqAccept}, 16'h1);
    irqLevel = 2'd2; #1;
    check(irqAccept == 1'b0, "R12 equal level refused", {15'h0, irqAccept}, 16'h0);
    irqLevel = 2'd3; #1;
    check(irqAccept == 1'b0, "R12 higher level refused", {15'h0, irqAccept}, 16'h0);
    irqReq = 1'b0; irqLevel = 2'd0; #1;
    check(irqAccept == 1'b0, "R12 no request", {15'h0, irqAccept}, 16'h0);
    presetCcr(8'h20);
    irqReq = 1'b1; irqLevel = 2'd0; #1;
    check(irqAccept == 1'b0, "R12 disabled", {15'h0, irqAccept}, 16'h0);
    presetCcr(8'h40);
    #1;
    check(irqAccept == 1'b0, "R12 level field zero", {15'h0, irqAccept}, 16'h0);
    irqReq = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule